// File: doc/BRIEF.md
# Synchronous FIFO with Programmable Level Flags

This block is a single-clock first-in first-out buffer. Its default geometry is 64 words of 18 bits. A write is accepted on `wr_en` unless the buffer is full. A read is accepted on `rd_en` unless the buffer is empty, and the word being read appears on `dout` after the clock edge that accepts the read.

Five active-low level flags are decoded from the current occupancy:

- empty
- almost empty
- more than half full
- almost full
- full

The almost-empty threshold and the almost-full threshold are held in two offset registers. Both registers come up at 7 after reset. They can be rewritten through the normal write port while `cfg_load` is held high.

A rewind strobe moves the read side back to the first storage location. This lets the stored contents be read out again, as often as needed. Words written after the rewind are also delivered.

Top module: `pflag_fifo`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears both addresses and the occupancy, sets both offsets to 7 and clears `dout` to 0. After reset, `empty_n` and `aempty_n` are low, and `half_n`, `afull_n` and `full_n` are high.
- R2: Words are read out in the order they were accepted. `dout` takes the read word on the same clock edge that accepts the read.
- R3: `empty_n` is low exactly when occupancy is 0.
- R4: `aempty_n` is low exactly when occupancy is less than or equal to the empty offset.
- R5: `half_n` is low exactly when occupancy is greater than DEPTH/2 (33 or more at the default depth).
- R6: `afull_n` is low exactly when occupancy is greater than or equal to DEPTH minus the full offset.
- R7: `full_n` is low exactly when occupancy equals DEPTH, and occupancy never exceeds DEPTH.
- R8: A write while full is ignored and leaves the stored data unchanged. A read while empty is ignored and leaves `dout` unchanged.
- R9: While `cfg_load` is high, each cycle with `wr_en` high loads `din[5:0]` into an offset register and stores nothing in the FIFO. The first such write goes to the empty offset, the next to the full offset, and then they alternate. The alternation restarts at the empty offset whenever `cfg_load` is low.
- R10: In a cycle with `rewind` high, the read address becomes 0. Occupancy becomes the current write address, or DEPTH when the write address is 0 and at least DEPTH words have been written since reset. Reads and data writes in that cycle are ignored, and the flags show the new occupancy after that edge.
- R11: After a rewind, reads return the words from location 0 onward, followed by any words written after the rewind. A second rewind replays the same words again.
- R12: A read and a write in the same cycle, with the FIFO neither empty nor full, leave the occupancy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for both sides |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write request |
| rd_en | input | 1 | Read request |
| cfg_load | input | 1 | Routes writes to the offset registers instead of the FIFO |
| rewind | input | 1 | Restarts reading from location 0 |
| din | input | DATA_W (18) | Write data; the low 6 bits carry offsets during a load |
| dout | output | DATA_W (18) | Registered read data |
| empty_n | output | 1 | Low when empty |
| aempty_n | output | 1 | Low when occupancy is at or below the empty offset |
| half_n | output | 1 | Low when more than half full |
| afull_n | output | 1 | Low when occupancy is at or above DEPTH minus the full offset |
| full_n | output | 1 | Low when full |

## Verification
The bench builds the block with its default parameters: 18-bit words, 64 entries and both offsets at 7.

A depth of 64 is small enough for the bench to fill the buffer completely and drain it again. Along the way, every flag threshold is crossed in both directions, including the half-full edge between 32 and 33 words.

It also reaches the lapped case, where the write address returns to 0 after exactly 64 writes, so that a rewind replays the full depth. Loaded offsets of 3 and 10 move the almost-empty and almost-full edges away from their defaults, so the comparisons are checked at thresholds other than the reset values.

// File: rtl/pff_pkg.sv
// Shared types for the programmable-flag FIFO.
package pff_pkg;

    // Active-low level flags, ordered from least to most occupied.
    typedef struct packed {
        logic empty_n;
        logic aempty_n;
        logic half_n;
        logic afull_n;
        logic full_n;
    } pff_flags_t;

endpackage

// File: rtl/pff_mem.sv
// Storage array with a single write port and a registered read port.
// Assumes the controller never reads and writes the same address in one cycle
// (a read is only granted when occupancy is nonzero).
module pff_mem #(
    parameter int DATA_W = 18,
    parameter int DEPTH  = 64,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ok,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd_ok,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] store [DEPTH];

    // Capture a granted write into the array.
    always_ff @(posedge clk) begin
        if (wr_ok) begin
            store[waddr] <= wdata;
        end
    end

    // Register the read word on a granted read; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_ok) begin
            rdata <= store[raddr];
        end
    end

    // R8
    dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_ok |=> $stable(rdata));

endmodule

// File: rtl/pff_ctrl.sv
// Address and occupancy control. Grants writes and reads, tracks occupancy
// and handles rewind. Assumes DEPTH is a power of two so that the
// addresses wrap naturally.
module pff_ctrl #(
    parameter int DEPTH = 64,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              cfg_load,
    input  logic              rewind,
    output logic              wr_ok,
    output logic              rd_ok,
    output logic [ADDR_W-1:0] waddr,
    output logic [ADDR_W-1:0] raddr,
    output logic [CNT_W-1:0]  count
);

    localparam logic [CNT_W-1:0]  FULL_CNT = CNT_W'(DEPTH);
    localparam logic [ADDR_W-1:0] LAST_A   = ADDR_W'(DEPTH - 1);

    logic             lapped;
    logic [CNT_W-1:0] rewind_cnt;

    // Grant logic: rewind blocks both sides, a load steals the write.
    always_comb begin
        wr_ok = wr_en && !cfg_load && !rewind && (count != FULL_CNT);
        rd_ok = rd_en && !rewind && (count != '0);
    end

    // Occupancy a rewind restores: from location 0 up to the write address.
    always_comb begin
        if (waddr == '0 && lapped) begin
            rewind_cnt = FULL_CNT;
        end else begin
            rewind_cnt = CNT_W'(waddr);
        end
    end

    // Advance the write address and note the first wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            waddr  <= '0;
            lapped <= 1'b0;
        end else if (wr_ok) begin
            waddr <= waddr + 1'b1;
            if (waddr == LAST_A) begin
                lapped <= 1'b1;
            end
        end
    end

    // Advance the read address, or return it to 0 on rewind.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raddr <= '0;
        end else if (rewind) begin
            raddr <= '0;
        end else if (rd_ok) begin
            raddr <= raddr + 1'b1;
        end
    end

    // Track occupancy from the grants, or reload it on rewind.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (rewind) begin
            count <= rewind_cnt;
        end else begin
            case ({wr_ok, rd_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (count == '0 && waddr == '0 && raddr == '0));
    // R7
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);
    // R8
    full_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count == FULL_CNT && wr_en && !rd_en && !rewind) |=> ($stable(count) && $stable(waddr)));
    // R8
    empty_read_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0 && rd_en && !wr_en && !rewind) |=> ($stable(raddr) && $stable(count)));
    // R10
    rewind_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rewind |=> (raddr == '0 && $stable(waddr)));
    // R12
    simul_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_en && !cfg_load && !rewind && count != '0 && count != FULL_CNT)
        |=> $stable(count));

endmodule

// File: rtl/pff_offsets.sv
// Almost-empty and almost-full offset registers. While the load input is
// high, each write alternately updates the empty offset and then the full
// offset. Assumes the offset field fits in the data word.
module pff_offsets #(
    parameter int DEPTH      = 64,
    parameter int AE_DEFAULT = 7,
    parameter int AF_DEFAULT = 7,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_load,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] value,
    output logic [ADDR_W-1:0] ae_off,
    output logic [ADDR_W-1:0] af_off
);

    logic pick_full;

    // Load the selected offset and step the selector; re-arm it when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ae_off    <= ADDR_W'(AE_DEFAULT);
            af_off    <= ADDR_W'(AF_DEFAULT);
            pick_full <= 1'b0;
        end else if (cfg_load) begin
            if (wr_en) begin
                if (pick_full) begin
                    af_off <= value;
                end else begin
                    ae_off <= value;
                end
                pick_full <= !pick_full;
            end
        end else begin
            pick_full <= 1'b0;
        end
    end

    // R9
    offsets_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_load && wr_en) |=> ($stable(ae_off) && $stable(af_off)));

endmodule

// File: rtl/pff_flags.sv
// Decodes the five active-low level flags from occupancy and offsets.
// Purely combinational; the flags follow the occupancy register.
module pff_flags #(
    parameter int DEPTH = 64,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CNT_W-1:0]    count,
    input  logic [ADDR_W-1:0]   ae_off,
    input  logic [ADDR_W-1:0]   af_off,
    output pff_pkg::pff_flags_t flags
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] HALF_CNT = CNT_W'(DEPTH / 2);

    logic [CNT_W-1:0] af_level;

    // Occupancy at which almost-full starts.
    always_comb af_level = FULL_CNT - CNT_W'(af_off);

    // Compare occupancy against each threshold.
    always_comb begin
        flags.empty_n  = (count != '0);
        flags.aempty_n = (count > CNT_W'(ae_off));
        flags.half_n   = !(count > HALF_CNT);
        flags.afull_n  = (count < af_level);
        flags.full_n   = (count != FULL_CNT);
    end

    // R3
    empty_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flags.empty_n |-> (!flags.aempty_n && flags.half_n && flags.full_n));
    // R7
    full_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flags.full_n |-> (!flags.afull_n && !flags.half_n && flags.empty_n));

endmodule

// File: rtl/pflag_fifo.sv
// Top level: single-clock FIFO with five active-low level flags,
// programmable almost-empty and almost-full offsets, and rewind.
// Assumes DEPTH is a power of two and DATA_W is at least log2(DEPTH).
module pflag_fifo #(
    parameter int DATA_W     = 18,
    parameter int DEPTH      = 64,
    parameter int AE_DEFAULT = 7,
    parameter int AF_DEFAULT = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              cfg_load,
    input  logic              rewind,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              empty_n,
    output logic              aempty_n,
    output logic              half_n,
    output logic              afull_n,
    output logic              full_n
);

    localparam int ADDR_W = $clog2(DEPTH);
    localparam int CNT_W  = $clog2(DEPTH + 1);

    logic                wr_ok;
    logic                rd_ok;
    logic [ADDR_W-1:0]   waddr;
    logic [ADDR_W-1:0]   raddr;
    logic [CNT_W-1:0]    count;
    logic [ADDR_W-1:0]   ae_off;
    logic [ADDR_W-1:0]   af_off;
    pff_pkg::pff_flags_t flags;

    pff_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .cfg_load(cfg_load), .rewind(rewind), .wr_ok(wr_ok), .rd_ok(rd_ok),
        .waddr(waddr), .raddr(raddr), .count(count)
    );

    pff_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
        .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok), .waddr(waddr), .wdata(din),
        .rd_ok(rd_ok), .raddr(raddr), .rdata(dout)
    );

    pff_offsets #(.DEPTH(DEPTH), .AE_DEFAULT(AE_DEFAULT), .AF_DEFAULT(AF_DEFAULT)) u_offsets (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .wr_en(wr_en),
        .value(din[ADDR_W-1:0]), .ae_off(ae_off), .af_off(af_off)
    );

    pff_flags #(.DEPTH(DEPTH)) u_flags (
        .clk(clk), .rst_n(rst_n), .count(count), .ae_off(ae_off),
        .af_off(af_off), .flags(flags)
    );

    // Present the flag vector on individual pins.
    always_comb begin
        empty_n  = flags.empty_n;
        aempty_n = flags.aempty_n;
        half_n   = flags.half_n;
        afull_n  = flags.afull_n;
        full_n   = flags.full_n;
    end

endmodule

// File: tb/tb_pflag_fifo.sv
`timescale 1ns/1ps
// Directed bench: a behavioural model written from the requirements predicts
// dout and every flag after each cycle.
module tb_pflag_fifo;

    localparam int DW    = 18;
    localparam int DEPTH = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0, rd_en = 1'b0, cfg_load = 1'b0, rewind = 1'b0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          empty_n, aempty_n, half_n, afull_n, full_n;

    int n_checks = 0;
    int n_fails  = 0;

    // model state
    logic [DW-1:0] m_mem [DEPTH];
    int            m_cnt, m_w, m_r, m_n, m_m;
    bit            m_lapped, m_sel;
    logic [DW-1:0] m_dout;

    pflag_fifo dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .cfg_load(cfg_load), .rewind(rewind), .din(din), .dout(dout),
        .empty_n(empty_n), .aempty_n(aempty_n), .half_n(half_n),
        .afull_n(afull_n), .full_n(full_n)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s %s: got %h expected %h (t=%0t)", tag, what, got, exp, $time);
        end
    endtask

    // Compare dout and all five flags with the model.
    task automatic check_all(input string ctx);
        chk(ctx, "dout R2", 32'(dout), 32'(m_dout));
        chk("R3", "empty_n", 32'(empty_n), 32'(m_cnt != 0));
        chk("R4", "aempty_n", 32'(aempty_n), 32'(m_cnt > m_n));
        chk("R5", "half_n", 32'(half_n), 32'(!(m_cnt > DEPTH / 2)));
        chk("R6", "afull_n", 32'(afull_n), 32'(m_cnt < DEPTH - m_m));
        chk("R7", "full_n", 32'(full_n), 32'(m_cnt != DEPTH));
    endtask

    task automatic model_reset();
        m_cnt = 0; m_w = 0; m_r = 0; m_n = 7; m_m = 7;
        m_lapped = 1'b0; m_sel = 1'b0; m_dout = '0;
    endtask

    // One cycle: drive at a falling edge, update model, check at next falling edge.
    task automatic step(input bit w, input bit r, input bit ld, input bit rw,
                        input logic [DW-1:0] d, input string ctx);
        bit wok, rok;
        wr_en = w; rd_en = r; cfg_load = ld; rewind = rw; din = d;
        wok = w && !ld && !rw && (m_cnt < DEPTH);
        rok = r && !rw && (m_cnt > 0);
        if (ld && w) begin
            if (m_sel) m_m = int'(d[5:0]);
            else       m_n = int'(d[5:0]);
            m_sel = !m_sel;
        end else if (!ld) begin
            m_sel = 1'b0;
        end
        if (rw) begin
            m_r = 0;
            m_cnt = (m_w == 0 && m_lapped) ? DEPTH : m_w;
        end else begin
            if (rok) begin
                m_dout = m_mem[m_r];
                m_r = (m_r + 1) % DEPTH;
            end
            if (wok) begin
                m_mem[m_w] = d;
                if (m_w == DEPTH - 1) m_lapped = 1'b1;
                m_w = (m_w + 1) % DEPTH;
            end
            m_cnt = m_cnt + int'(wok) - int'(rok);
        end
        @(negedge clk);
        wr_en = 0; rd_en = 0; cfg_load = 0; rewind = 0;
        check_all(ctx);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    // R1: reset state of data and flags
    task automatic t_reset();
        do_reset();
        chk("R1", "dout", 32'(dout), 32'h0);
        chk("R1", "empty_n", 32'(empty_n), 32'h0);
        chk("R1", "aempty_n", 32'(aempty_n), 32'h0);
        chk("R1", "half_n", 32'(half_n), 32'h1);
        chk("R1", "afull_n", 32'(afull_n), 32'h1);
        chk("R1", "full_n", 32'(full_n), 32'h1);
    endtask

    // R2, R8: fill to full, overflow attempt, drain, underflow attempt
    task automatic t_fill_drain();
        do_reset();
        for (int i = 0; i < DEPTH; i++) step(1, 0, 0, 0, DW'(i * 4099 + 5), "R2");
        step(1, 0, 0, 0, 18'h3ffff, "R8");
        for (int i = 0; i < DEPTH; i++) step(0, 1, 0, 0, '0, "R2");
        step(0, 1, 0, 0, '0, "R8");
        step(0, 1, 0, 0, '0, "R8");
    endtask

    // R9: load offsets 3 and 10, sweep occupancy, then restart the alternation
    task automatic t_load();
        do_reset();
        step(1, 0, 1, 0, 18'h00003, "R9");
        step(1, 0, 1, 0, 18'h0000a, "R9");
        for (int i = 0; i < 60; i++) step(1, 0, 0, 0, DW'(i + 100), "R9");
        step(1, 0, 1, 0, 18'h00005, "R9");
        step(0, 0, 0, 0, '0, "R9");
        step(1, 0, 1, 0, 18'h00020, "R9");
        for (int i = 0; i < 30; i++) step(0, 1, 0, 0, '0, "R9");
    endtask

    // R12: simultaneous traffic keeps occupancy steady
    task automatic t_simul();
        do_reset();
        for (int i = 0; i < 20; i++) step(1, 0, 0, 0, DW'(i * 7 + 1), "R12");
        for (int i = 0; i < 12; i++) step(1, 1, 0, 0, DW'(i + 500), "R12");
        for (int i = 0; i < 20; i++) step(0, 1, 0, 0, '0, "R12");
    endtask

    // R10, R11: partial replay, repeat, lapped full replay, ignored traffic
    task automatic t_rewind();
        do_reset();
        for (int i = 0; i < 10; i++) step(1, 0, 0, 0, DW'(i + 1000), "R10");
        for (int i = 0; i < 4; i++) step(0, 1, 0, 0, '0, "R10");
        step(0, 0, 0, 1, '0, "R10");
        for (int i = 0; i < 10; i++) step(0, 1, 0, 0, '0, "R11");
        step(1, 0, 0, 0, 18'h2aaaa, "R11");
        step(1, 0, 0, 0, 18'h15555, "R11");
        step(0, 1, 0, 0, '0, "R11");
        step(0, 0, 0, 1, '0, "R11");
        for (int i = 0; i < 13; i++) step(0, 1, 0, 0, '0, "R11");
        do_reset();
        for (int i = 0; i < DEPTH; i++) step(1, 0, 0, 0, DW'(i * 3 + 2), "R10");
        for (int i = 0; i < DEPTH; i++) step(0, 1, 0, 0, '0, "R10");
        step(1, 1, 0, 1, 18'h12345, "R10");
        for (int i = 0; i < DEPTH; i++) step(0, 1, 0, 0, '0, "R11");
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_fill_drain();
        t_load();
        t_simul();
        t_rewind();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule